// File: doc/BRIEF.md
# Flagged RDS Block Buffer

This block sits between an RDS block decoder and a serial readout shifter. Each decoded block arrives on a one-cycle write port. It carries 16 data bits, a 3-bit offset-word code, an offset-detected flag, an ARI flag and a 3-bit error code. The block stamps each stored block with the sync state seen at the moment it arrives. Up to 24 blocks are held in a circular store.

When chip select rises, the head block is packed into a 32-bit readout word. The word carries a fixed header and the fill-level flags as they stand at that moment. A shifter then pulses `bit_tick` once per bit sent. A block counts as consumed once 31 of its bits have gone out.

A write policy decides which blocks are kept. It looks at the sync state and a keep-unsynchronized option. It also keeps the most recent pre-lock blocks after a sync reset and releases them once lock is reached. An active-low request line tells the host that data is waiting. That line is held high for a programmable holdoff after every read.

Top module: `rds_blk_buffer`

## Requirements
- R1: The buffer holds at most DEPTH (24) blocks. A block written while the buffer is full overwrites the oldest entry, and the fill count stays at DEPTH.
- R2: The readout word holds the following fields, by bit position:
  - bits 31:28 = 1010;
  - bit 27 = offset-detected flag;
  - bits 26:24 = offset code (000 A, 001 B, 010 C, 011 C', 100 D, 101 E);
  - bit 23 = more-data flag;
  - bits 22:21 = fill code;
  - bit 20 = ARI flag;
  - bit 19 = sync-at-reception flag;
  - bits 18:16 = error code;
  - bits 15:0 = block data.
- R3: The more-data flag (bit 23) is 1 when at least one further block is held behind the one being read, and 0 when this block is the last one held.
- R4: The fill code (bits 22:21) is set from the count held when the word is latched, including the block being read: 00 for 1–7, 01 for 8–15, 10 for 16–23, 11 for 24.
- R5: A word latched while the buffer is empty is all zeros, and reading it consumes nothing.
- R6: A block that arrives while unlocked is dropped when `keep_unsync`=0. When `keep_unsync`=1 it is stored with its sync flag (bit 19) at 0.
- R7: A `sync_rst` pulse empties the buffer. Until `sync_locked` rises, arriving blocks are staged, and only the last PRE_DEPTH (3) of them are kept. They stay invisible and `req_n` stays high. When lock rises, the staged blocks become readable ahead of any later block and are counted in the fill level.
- R8: `req_n` is low only when at least one readable block is held, chip select is low and the holdoff has expired. It is high whenever chip select is high.
- R9: After chip select falls, `req_n` stays high for HOLD_CYC clock cycles, then goes low if data remains.
- R10: A read that ends after fewer than 31 bit ticks leaves the block in place, so the next read returns the same block. A read that ends after 31 or 32 ticks consumes the block.
- R11: When a block is written in the same cycle as a block is consumed, the fill count is unchanged, even when the buffer is full, and no other block is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| blk_valid | input | 1 | One-cycle strobe: a decoded block is present |
| blk_data | input | 16 | Block data bits |
| blk_ofs | input | 3 | Offset-word code |
| blk_owd | input | 1 | Offset word was detected (not protected) |
| blk_ari | input | 1 | ARI signal detected |
| blk_err | input | 3 | Error/correction code |
| sync_locked | input | 1 | Current block-sync state from the detector |
| keep_unsync | input | 1 | Store blocks received while unlocked |
| sync_rst | input | 1 | Sync and buffer reset |
| cs | input | 1 | Chip select of the serial read |
| bit_tick | input | 1 | One pulse per readout bit shifted out |
| rd_word | output | 32 | Latched readout word for the shifter |
| req_n | output | 1 | Active-low read request |

## Verification
The coincidence that matters is a new block arriving in the same cycle as the 31st bit tick of a read. This is sharpest when the buffer already holds 24 blocks: the overwrite path and the consume path then compete for the read pointer. The bench fills the store, starts a read and raises `blk_valid` exactly on the 31st tick. It then checks three things against its queue model: the word latched on the 32nd tick is the second-oldest block, that word still reports a fill code of 11, and the drained sequence ends with the new block. The checker separately requires the fill count to be stable across any such cycle.

// File: rtl/rds_buf_pkg.sv
package rds_buf_pkg;

  typedef struct packed {
    logic [15:0] data;
    logic [2:0]  ofs;
    logic        owd;
    logic        ari;
    logic        syc;
    logic [2:0]  err;
  } rds_entry_t;

  // Coarse fill level, thresholds at thirds of the capacity
  function automatic logic [1:0] fill_code(input int unsigned cnt, input int unsigned depth);
    if (cnt >= depth)             return 2'b11;
    else if (cnt >= 2 * depth / 3) return 2'b10;
    else if (cnt >= depth / 3)     return 2'b01;
    else                           return 2'b00;
  endfunction

  // Readout word; cnt is the number held including the head
  function automatic logic [31:0] pack_word(input rds_entry_t e, input int unsigned cnt,
                                            input int unsigned depth);
    logic more;
    if (cnt == 0) return 32'h0;
    more = (cnt > 1);
    return {4'b1010, e.owd, e.ofs, more, fill_code(cnt, depth), e.ari, e.syc, e.err, e.data};
  endfunction

endpackage

// File: rtl/rds_buf_store.sv
module rds_buf_store
  import rds_buf_pkg::*;
#(
  parameter int DEPTH = 24,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  rds_entry_t    wdata,
  input  logic [AW-1:0] raddr,
  output rds_entry_t    rdata
);
  rds_entry_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rds_buf_ctrl.sv
module rds_buf_ctrl #(
  parameter int DEPTH     = 24,
  parameter int PRE_DEPTH = 3,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SW = $clog2(PRE_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic          sync_locked,
  input  logic          keep_unsync,
  input  logic          sync_rst,
  input  logic          pop_req,
  output logic          wr_fire,
  output logic          pop_fire,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] fill_cnt,
  output logic          armed
);
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] count;
  logic [SW-1:0] stage;
  logic          armed_q;
  logic          full, staging;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (count == CW'(DEPTH));
  assign staging  = armed_q && !sync_locked;
  assign wr_fire  = wr_valid && !sync_rst && (armed_q || sync_locked || keep_unsync);
  assign pop_fire = pop_req && !sync_rst && (count != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      count   <= '0;
      stage   <= '0;
      armed_q <= 1'b0;
    end else if (sync_rst) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      count   <= '0;
      stage   <= '0;
      armed_q <= 1'b1;
    end else begin
      if (wr_fire) wr_ptr <= ptr_inc(wr_ptr);
      if (staging) begin
        // keep only the newest PRE_DEPTH pre-lock blocks
        if (wr_fire) begin
          if (stage == SW'(PRE_DEPTH)) rd_ptr <= ptr_inc(rd_ptr);
          else                         stage  <= stage + 1'b1;
        end
      end else if (armed_q) begin
        // lock reached: release staged blocks ahead of later ones
        armed_q <= 1'b0;
        stage   <= '0;
        count   <= CW'(stage) + CW'(wr_fire);
      end else begin
        if (pop_fire || (wr_fire && full)) rd_ptr <= ptr_inc(rd_ptr);
        if (wr_fire && !pop_fire && !full) count <= count + 1'b1;
        else if (pop_fire && !wr_fire)     count <= count - 1'b1;
      end
    end
  end

  assign waddr    = wr_ptr;
  assign raddr    = rd_ptr;
  assign fill_cnt = count;
  assign armed    = armed_q;
endmodule

// File: rtl/rds_buf_reader.sv
module rds_buf_reader
  import rds_buf_pkg::*;
#(
  parameter int DEPTH = 24,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          bit_tick,
  input  logic          sync_rst,
  input  rds_entry_t    head,
  input  logic [CW-1:0] fill_cnt,
  output logic [31:0]   rd_word,
  output logic          pop_req,
  output logic          latch_evt
);
  logic        cs_q, valid_q, tick, cs_rise, last_tick;
  logic [5:0]  bit_cnt;
  logic [31:0] word_q;

  assign cs_rise   = cs && !cs_q;
  assign tick      = cs && cs_q && bit_tick;
  assign last_tick = tick && (bit_cnt == 6'd31);
  assign latch_evt = cs_rise || last_tick;
  // consumed once only the final bit is left
  assign pop_req   = tick && (bit_cnt == 6'd30) && valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q    <= 1'b0;
      bit_cnt <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      cs_q <= cs;
      if (!cs || latch_evt) bit_cnt <= '0;
      else if (tick)        bit_cnt <= bit_cnt + 1'b1;
      if (latch_evt) begin
        word_q  <= pack_word(head, 32'(fill_cnt), DEPTH);
        valid_q <= (fill_cnt != '0) && !sync_rst;
      end else if (sync_rst) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign rd_word = word_q;
endmodule

// File: rtl/rds_buf_reqline.sv
module rds_buf_reqline #(
  parameter int HOLD_CYC = 1060,
  localparam int HW = $clog2(HOLD_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic avail,
  output logic req_n,
  output logic hold_busy
);
  logic          cs_q;
  logic [HW-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b0;
      hold_q <= '0;
    end else begin
      cs_q <= cs;
      if (cs_q && !cs)       hold_q <= HW'(HOLD_CYC);
      else if (hold_q != '0) hold_q <= hold_q - 1'b1;
    end
  end

  assign hold_busy = (hold_q != '0);
  assign req_n     = !(avail && !hold_busy && !cs && !cs_q);
endmodule

// File: rtl/rds_blk_buffer.sv
module rds_blk_buffer
  import rds_buf_pkg::*;
#(
  parameter int DEPTH     = 24,
  parameter int PRE_DEPTH = 3,
  parameter int HOLD_CYC  = 1060
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        blk_valid,
  input  logic [15:0] blk_data,
  input  logic [2:0]  blk_ofs,
  input  logic        blk_owd,
  input  logic        blk_ari,
  input  logic [2:0]  blk_err,
  input  logic        sync_locked,
  input  logic        keep_unsync,
  input  logic        sync_rst,
  input  logic        cs,
  input  logic        bit_tick,
  output logic [31:0] rd_word,
  output logic        req_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  rds_entry_t    wr_ent, head_ent;
  logic          wr_fire, pop_fire, pop_req, armed, latch_evt, hold_busy;
  logic [AW-1:0] waddr, raddr;
  logic [CW-1:0] fill_cnt;

  always_comb begin
    wr_ent.data = blk_data;
    wr_ent.ofs  = blk_ofs;
    wr_ent.owd  = blk_owd;
    wr_ent.ari  = blk_ari;
    wr_ent.syc  = sync_locked;
    wr_ent.err  = blk_err;
  end

  rds_buf_ctrl #(.DEPTH(DEPTH), .PRE_DEPTH(PRE_DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(blk_valid), .sync_locked(sync_locked),
    .keep_unsync(keep_unsync), .sync_rst(sync_rst), .pop_req(pop_req),
    .wr_fire(wr_fire), .pop_fire(pop_fire), .waddr(waddr), .raddr(raddr),
    .fill_cnt(fill_cnt), .armed(armed)
  );

  rds_buf_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .we(wr_fire), .waddr(waddr), .wdata(wr_ent),
    .raddr(raddr), .rdata(head_ent)
  );

  rds_buf_reader #(.DEPTH(DEPTH)) u_reader (
    .clk(clk), .rst_n(rst_n), .cs(cs), .bit_tick(bit_tick), .sync_rst(sync_rst),
    .head(head_ent), .fill_cnt(fill_cnt), .rd_word(rd_word),
    .pop_req(pop_req), .latch_evt(latch_evt)
  );

  rds_buf_reqline #(.HOLD_CYC(HOLD_CYC)) u_req (
    .clk(clk), .rst_n(rst_n), .cs(cs), .avail(fill_cnt != '0),
    .req_n(req_n), .hold_busy(hold_busy)
  );
endmodule

// File: rtl/rds_blk_buffer_chk.sv
module rds_blk_buffer_chk #(
  parameter int DEPTH = 24,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          req_n,
  input logic          sync_rst,
  input logic          armed,
  input logic          wr_fire,
  input logic          pop_fire,
  input logic          latch_evt,
  input logic          hold_busy,
  input logic [CW-1:0] fill_cnt,
  input logic [31:0]   rd_word
);
  p_fill_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fill_cnt <= CW'(DEPTH));

  p_full_overwrite_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == CW'(DEPTH) && wr_fire && !pop_fire && !armed) |=> fill_cnt == CW'(DEPTH));

  p_header_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_evt && fill_cnt != '0) |=> rd_word[31:28] == 4'b1010);

  p_empty_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_evt && fill_cnt == '0) |=> rd_word == 32'h0);

  p_sync_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_rst |=> (fill_cnt == '0 && req_n));

  p_req_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_cnt == '0 || cs) |-> req_n);

  p_holdoff_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs && $past(cs)) |=> (req_n && hold_busy));

  p_same_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && pop_fire && !armed) |=> $stable(fill_cnt));
endmodule

bind rds_blk_buffer rds_blk_buffer_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .req_n(req_n), .sync_rst(sync_rst),
  .armed(armed), .wr_fire(wr_fire), .pop_fire(pop_fire), .latch_evt(latch_evt),
  .hold_busy(hold_busy), .fill_cnt(fill_cnt), .rd_word(rd_word)
);

// File: tb/rds_blk_buffer_bench.sv
`timescale 1ns/1ps
module rds_blk_buffer_bench;
  localparam int DEPTH = 24;
  localparam int PRE   = 3;
  localparam int HOLD  = 1060;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        blk_valid = 1'b0;
  logic [15:0] blk_data = '0;
  logic [2:0]  blk_ofs = '0;
  logic        blk_owd = 1'b0, blk_ari = 1'b0;
  logic [2:0]  blk_err = '0;
  logic        sync_locked = 1'b0, keep_unsync = 1'b0, sync_rst = 1'b0;
  logic        cs = 1'b0, bit_tick = 1'b0;
  logic [31:0] rd_word;
  logic        req_n;

  int checks = 0;
  int errors = 0;
  // bench entry layout: {owd, ofs[2:0], ari, syc, err[2:0], data[15:0]}
  logic [24:0] model[$];
  logic [24:0] stage_q[$];

  always #2 clk = ~clk;

  rds_blk_buffer #(.DEPTH(DEPTH), .PRE_DEPTH(PRE), .HOLD_CYC(HOLD)) u_rds_blk_buffer (
    .clk(clk), .rst_n(rst_n), .blk_valid(blk_valid), .blk_data(blk_data),
    .blk_ofs(blk_ofs), .blk_owd(blk_owd), .blk_ari(blk_ari), .blk_err(blk_err),
    .sync_locked(sync_locked), .keep_unsync(keep_unsync), .sync_rst(sync_rst),
    .cs(cs), .bit_tick(bit_tick), .rd_word(rd_word), .req_n(req_n)
  );

  function automatic logic [31:0] exp_word(input logic [24:0] e, input int n);
    logic [1:0] rf;
    if (n == 0) return 32'h0;
    rf = (n == 24) ? 2'b11 : (n >= 16) ? 2'b10 : (n >= 8) ? 2'b01 : 2'b00;
    return {4'b1010, e[24], e[23:21], (n > 1), rf, e[20], e[19], e[18:16], e[15:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  // driver: sends one block, pushes it to the scoreboard when it must be stored
  task automatic put_block(input logic [15:0] d, input logic [2:0] o, input logic ow,
                           input logic ar, input logic [2:0] er, input bit to_model,
                           input bit to_stage);
    blk_data = d; blk_ofs = o; blk_owd = ow; blk_ari = ar; blk_err = er;
    blk_valid = 1'b1;
    step();
    blk_valid = 1'b0;
    if (to_model) begin
      if (model.size() == DEPTH) void'(model.pop_front());
      model.push_back({ow, o, ar, sync_locked, er, d});
    end
    if (to_stage) begin
      if (stage_q.size() == PRE) void'(stage_q.pop_front());
      stage_q.push_back({ow, o, ar, 1'b0, er, d});
    end
  endtask

  task automatic do_read(input int nbits, output logic [31:0] w);
    cs = 1'b1;
    step();
    w = rd_word;
    bit_tick = 1'b1;
    repeat (nbits) step();
    bit_tick = 1'b0;
    cs = 1'b0;
    step();
  endtask

  // monitor side: compare a full read with the scoreboard head
  task automatic read_check(input string req);
    logic [31:0] w;
    do_read(32, w);
    if (model.size() > 0) begin
      chk(req, w, exp_word(model[0], model.size()));
      void'(model.pop_front());
    end else begin
      chk(req, w, 32'h0);
    end
  endtask

  task automatic wait_hold();
    repeat (HOLD + 2) step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] w;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // reset state
    chk("R8 reset req_n", {31'd0, req_n}, 32'd1);
    read_check("R5 empty read after reset");
    wait_hold();

    // R6: unlocked block dropped when keep_unsync=0
    put_block(16'h1111, 3'b000, 1'b1, 1'b0, 3'b000, 1'b0, 1'b0);
    step();
    chk("R6 dropped block leaves req_n high", {31'd0, req_n}, 32'd1);
    read_check("R6 dropped block not readable");
    wait_hold();

    // R6: kept with sync flag 0 when keep_unsync=1
    keep_unsync = 1'b1;
    put_block(16'h2222, 3'b011, 1'b0, 1'b1, 3'b110, 1'b1, 1'b0);
    keep_unsync = 1'b0;
    step();
    chk("R8 req_n low with data", {31'd0, req_n}, 32'd0);
    read_check("R6 unsynced block stored with SYC=0");
    wait_hold();

    // R2/R3: locked blocks, varied fields
    sync_locked = 1'b1;
    put_block(16'hA5C3, 3'b001, 1'b1, 1'b0, 3'b010, 1'b1, 1'b0);
    put_block(16'h0F0F, 3'b101, 1'b1, 1'b1, 3'b001, 1'b1, 1'b0);
    put_block(16'hBEEF, 3'b100, 1'b0, 1'b0, 3'b000, 1'b1, 1'b0);
    read_check("R2 field order word one, R3 more flag set");
    // R9: holdoff after chip select falls
    chk("R9 req_n high right after read", {31'd0, req_n}, 32'd1);
    repeat (HOLD - 1) step();
    chk("R9 req_n high at end of holdoff", {31'd0, req_n}, 32'd1);
    step();
    chk("R9 req_n low after holdoff", {31'd0, req_n}, 32'd0);
    cs = 1'b1;
    step();
    chk("R8 req_n high while cs high", {31'd0, req_n}, 32'd1);
    cs = 1'b0;
    step();
    read_check("R2 word two");
    read_check("R3 last word has more flag clear");
    read_check("R5 empty after drain");

    // R10: aborted read returns the same word; 31 bits consume it
    put_block(16'h1234, 3'b010, 1'b1, 1'b0, 3'b011, 1'b1, 1'b0);
    put_block(16'h5678, 3'b011, 1'b1, 1'b1, 3'b100, 1'b1, 1'b0);
    do_read(10, w);
    chk("R10 partial read word", w, exp_word(model[0], model.size()));
    read_check("R10 same word after abort");
    do_read(31, w);
    chk("R10 31-bit read word", w, exp_word(model[0], model.size()));
    void'(model.pop_front());
    read_check("R10 31-bit read consumed");

    // R1/R4: overflow keeps newest 24, fill codes over a full drain
    for (int i = 0; i < DEPTH + 3; i++)
      put_block(16'h4000 + 16'(i), 3'(i % 6), i[0], i[1], 3'(i % 6), 1'b1, 1'b0);
    for (int i = 0; i < DEPTH; i++)
      read_check($sformatf("R1 R4 overflow drain word %0d", i));
    read_check("R1 empty after drain");

    // R11: write lands on the consuming tick with the buffer full
    for (int i = 0; i < DEPTH; i++)
      put_block(16'h7000 + 16'(i), 3'b100, 1'b1, 1'b0, 3'b000, 1'b1, 1'b0);
    cs = 1'b1;
    step();
    chk("R11 first word while full", rd_word, exp_word(model[0], DEPTH));
    bit_tick = 1'b1;
    repeat (30) step();
    blk_data = 16'hCAFE; blk_ofs = 3'b001; blk_owd = 1'b1; blk_ari = 1'b1; blk_err = 3'b001;
    blk_valid = 1'b1;
    step();
    blk_valid = 1'b0;
    void'(model.pop_front());
    model.push_back({1'b1, 3'b001, 1'b1, 1'b1, 3'b001, 16'hCAFE});
    step();
    bit_tick = 1'b0;
    chk("R11 next word keeps full code", rd_word, exp_word(model[0], DEPTH));
    cs = 1'b0;
    step();
    for (int i = 0; i < DEPTH; i++)
      read_check($sformatf("R11 drain word %0d", i));
    wait_hold();

    // R7: sync reset, staging, release on lock
    put_block(16'h9999, 3'b000, 1'b1, 1'b0, 3'b000, 1'b1, 1'b0);
    sync_locked = 1'b0;
    sync_rst = 1'b1;
    step();
    sync_rst = 1'b0;
    model.delete();
    for (int i = 0; i < 5; i++)
      put_block(16'h3300 + 16'(i), 3'(i), 1'b1, 1'b0, 3'b000, 1'b0, 1'b1);
    step();
    chk("R7 req_n high before lock", {31'd0, req_n}, 32'd1);
    sync_locked = 1'b1;
    step();
    foreach (stage_q[i]) model.push_back(stage_q[i]);
    put_block(16'h4444, 3'b011, 1'b1, 1'b1, 3'b010, 1'b1, 1'b0);
    step();
    chk("R7 req_n low after lock", {31'd0, req_n}, 32'd0);
    for (int i = 0; i < 4; i++)
      read_check($sformatf("R7 staged-then-new word %0d", i));
    read_check("R7 empty after release");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule